// File: doc/BRIEF.md
# Multiword DMA Device Request Handshake

This block is the device-side control for a 16-bit multiword DMA transfer. It raises the DMA request line when the device's data buffer can supply a word (device-to-host transfer) or accept a word (host-to-device transfer). It then completes one word each time the host pulses a read or write strobe under acknowledge. The word moves on the trailing edge of the strobe. The block issues a one-cycle pop pulse for a read and a one-cycle push pulse for a write, and the buffer logic uses these to advance.

Request and acknowledge form a strict four-phase handshake. Once raised, the request stays up until the host has shown acknowledge. After that, the request drops in two cases: the programmed block of words has moved, or the buffer can no longer keep up. The request is raised again only after the host has released acknowledge and data remains. The request driver is released whenever the device is not selected. The device drives the data bus only while acknowledge and the read strobe are both active.

Top module: `dma_req_hs`

## Requirements
- R1: After reset, `req_o`, `dd_oe_o`, `pop_o` and `push_o` are all low.
- R2: With `ack_i` low, `req_o` rises one clock after `sel_i`, `act_i` and the buffer status are all high. The buffer status is `src_rdy_i` when `dir_rd_i` is 1 and `snk_rdy_i` when `dir_rd_i` is 0.
- R3: Once raised, `req_o` stays high until `ack_i` has been seen high, even if the buffer status falls.
- R4: A falling edge of `rd_stb_i` while `ack_i` is high gives `pop_o` high for exactly one cycle. A falling edge of `wr_stb_i` under the same condition gives `push_o` for one cycle. Both pulses appear in the cycle after the strobe falls.
- R5: Strobe edges while `ack_i` is low produce no pulse and do not count toward the block.
- R6: `dd_oe_o` is high only while `ack_i` and `rd_stb_i` are both high.
- R7: `blk_words_i` gives the number of words per request; a value of 0 means 2^CNT_W words. `req_o` falls at the clock edge that follows the pulse of the last word of the block.
- R8: If the buffer status falls after `ack_i` has been seen, `req_o` falls at the next clock edge.
- R9: After `req_o` falls, it stays low while `ack_i` is high. It rises again two clocks after `ack_i` falls if the buffer status is still high.
- R10: `req_oe_o` follows `sel_i`. While `sel_i` is low, no new request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Device is selected |
| act_i | input | 1 | A DMA transfer is in progress |
| dir_rd_i | input | 1 | 1: device-to-host, 0: host-to-device |
| src_rdy_i | input | 1 | Buffer can supply a word |
| snk_rdy_i | input | 1 | Buffer can accept a word |
| blk_words_i | input | CNT_W | Words per request (0 = 2^CNT_W) |
| ack_i | input | 1 | Host DMA acknowledge, active high |
| rd_stb_i | input | 1 | Host read strobe, active high |
| wr_stb_i | input | 1 | Host write strobe, active high |
| req_o | output | 1 | DMA request value |
| req_oe_o | output | 1 | Output enable for the request driver |
| dd_oe_o | output | 1 | Data bus output enable |
| pop_o | output | 1 | One-cycle pulse: word read by host |
| push_o | output | 1 | One-cycle pulse: word written by host |

## Verification
The bound checker enforces the following properties on every cycle:
- the request never falls before acknowledge has been seen;
- the request never rises with acknowledge already high or without a ready buffer;
- the request never rises while deselected;
- a pulse never appears without acknowledge, and each pulse lasts one cycle;
- the bus enable is gated by acknowledge and the read strobe;
- no request moves more words than its block.

Other behaviour depends on exact cycle placement and is shown only by the bench sweep over every block size and both directions. This covers the exact word on which the request falls, the two-cycle re-raise after acknowledge is released, the pause when the buffer runs dry, and the fact that unacknowledged strobes leave the block count untouched.

// File: rtl/dma_req_hs_pkg.sv
package dma_req_hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_HOLD = 2'd2
  } hs_state_e;
endpackage

// File: rtl/dma_strobe_fall.sv
module dma_strobe_fall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic qual_i,
  output logic fall_o
);
  logic stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= stb_i;
  end

  // trailing edge of the strobe, qualified by acknowledge
  assign fall_o = stb_q & ~stb_i & qual_i;
endmodule

// File: rtl/dma_blk_cnt.sv
module dma_blk_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] blk_i,
  output logic             last_o
);
  localparam int unsigned LW = CNT_W + 1;

  logic [LW-1:0] cnt_q;
  logic [LW-1:0] lim;

  // zero encodes a full block of 2^CNT_W words
  assign lim = (blk_i == '0) ? LW'(1) << CNT_W : {1'b0, blk_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + LW'(1);
  end

  assign last_o = (cnt_q + LW'(1)) == lim;
endmodule

// File: rtl/dma_req_hs.sv
module dma_req_hs
  import dma_req_hs_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             act_i,
  input  logic             dir_rd_i,
  input  logic             src_rdy_i,
  input  logic             snk_rdy_i,
  input  logic [CNT_W-1:0] blk_words_i,
  input  logic             ack_i,
  input  logic             rd_stb_i,
  input  logic             wr_stb_i,
  output logic             req_o,
  output logic             req_oe_o,
  output logic             dd_oe_o,
  output logic             pop_o,
  output logic             push_o
);
  hs_state_e state_q, state_d;
  logic      ack_seen_q;
  logic      buf_ok, word, last, cnt_clr;

  dma_strobe_fall u_rd_fall (
    .clk_i (clk_i), .rst_ni(rst_ni), .stb_i(rd_stb_i), .qual_i(ack_i), .fall_o(pop_o)
  );

  dma_strobe_fall u_wr_fall (
    .clk_i (clk_i), .rst_ni(rst_ni), .stb_i(wr_stb_i), .qual_i(ack_i), .fall_o(push_o)
  );

  assign word    = pop_o | push_o;
  assign buf_ok  = sel_i & act_i & (dir_rd_i ? src_rdy_i : snk_rdy_i);
  assign cnt_clr = (state_q == ST_IDLE);

  dma_blk_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (word && state_q == ST_REQ),
    .blk_i (blk_words_i),
    .last_o(last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (buf_ok && !ack_i) state_d = ST_REQ;
      ST_REQ: begin
        if (word && last)                      state_d = ST_HOLD;
        else if ((ack_seen_q || ack_i) && !buf_ok) state_d = ST_HOLD;
      end
      ST_HOLD: if (!ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ack_seen_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_REQ) ack_seen_q <= 1'b0;
      else if (ack_i)        ack_seen_q <= 1'b1;
    end
  end

  assign req_o    = (state_q == ST_REQ);
  assign req_oe_o = sel_i;
  assign dd_oe_o  = ack_i & rd_stb_i;
endmodule

// File: rtl/dma_req_hs_chk.sv
module dma_req_hs_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             act_i,
  input logic             dir_rd_i,
  input logic             src_rdy_i,
  input logic             snk_rdy_i,
  input logic [CNT_W-1:0] blk_words_i,
  input logic             ack_i,
  input logic             rd_stb_i,
  input logic             req_o,
  input logic             dd_oe_o,
  input logic             pop_o,
  input logic             push_o
);
  localparam int unsigned WW = CNT_W + 2;

  logic          seen_q;
  logic [WW-1:0] wcnt_q;
  logic [WW-1:0] lim;

  assign lim = (blk_words_i == '0) ? WW'(1) << CNT_W : WW'(blk_words_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      wcnt_q <= '0;
    end else begin
      if (!req_o)      seen_q <= 1'b0;
      else if (ack_i)  seen_q <= 1'b1;
      if (!req_o)                    wcnt_q <= '0;
      else if (pop_o || push_o)      wcnt_q <= wcnt_q + WW'(1);
    end
  end

  p_rise_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(sel_i && act_i && (dir_rd_i ? src_rdy_i : snk_rdy_i)));

  p_hold_for_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> seen_q);

  p_pulse_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o || push_o) |=> !(pop_o || push_o));

  p_pulse_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o || push_o) |-> ack_i);

  p_dd_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dd_oe_o |-> (ack_i && rd_stb_i));

  p_block_limit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q <= lim);

  p_no_rise_acked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> !$past(ack_i));

  p_no_rise_unsel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && !sel_i) |=> !req_o);
endmodule

bind dma_req_hs dma_req_hs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .act_i      (act_i),
  .dir_rd_i   (dir_rd_i),
  .src_rdy_i  (src_rdy_i),
  .snk_rdy_i  (snk_rdy_i),
  .blk_words_i(blk_words_i),
  .ack_i      (ack_i),
  .rd_stb_i   (rd_stb_i),
  .req_o      (req_o),
  .dd_oe_o    (dd_oe_o),
  .pop_o      (pop_o),
  .push_o     (push_o)
);

// File: tb/dma_req_hs_bench.sv
`timescale 1ns/1ps
module dma_req_hs_bench;
  localparam int unsigned CNT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel, act, dir_rd, src_rdy, snk_rdy, ack, rd_stb, wr_stb;
  logic [CNT_W-1:0] blk;
  logic req, req_oe, dd_oe, pop, push;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  dma_req_hs #(.CNT_W(CNT_W)) u_dma_req_hs (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .act_i(act), .dir_rd_i(dir_rd),
    .src_rdy_i(src_rdy), .snk_rdy_i(snk_rdy), .blk_words_i(blk), .ack_i(ack),
    .rd_stb_i(rd_stb), .wr_stb_i(wr_stb), .req_o(req), .req_oe_o(req_oe),
    .dd_oe_o(dd_oe), .pop_o(pop), .push_o(push)
  );

  task automatic chk(input string tag, input logic act_v, input logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic nclk();
    @(negedge clk);
    #1;
  endtask

  // one strobe pulse; checks pulse, bus enable and request after the trailing edge
  task automatic word(input logic rd, input logic acked, input logic req_after);
    @(negedge clk);
    if (rd) rd_stb = 1'b1; else wr_stb = 1'b1;
    #1;
    chk("R6 dd_oe during strobe", dd_oe, rd & acked);
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0;
    #1;
    chk("R4/R5 pop pulse", pop, rd & acked);
    chk("R4/R5 push pulse", push, ~rd & acked);
    chk("R6 dd_oe after strobe", dd_oe, 1'b0);
    nclk();
    chk("R4 pulse one cycle", pop | push, 1'b0);
    chk("R7 request after word", req, req_after);
  endtask

  initial begin
    sel = 0; act = 0; dir_rd = 0; src_rdy = 0; snk_rdy = 0;
    ack = 0; rd_stb = 0; wr_stb = 0; blk = '0;
    #5;
    chk("R1 req reset", req, 1'b0);
    chk("R1 pop reset", pop, 1'b0);
    chk("R1 push reset", push, 1'b0);
    chk("R1 dd_oe reset", dd_oe, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R10: deselected, ready buffer, no request, driver released
    @(negedge clk);
    act = 1; dir_rd = 1; src_rdy = 1;
    repeat (3) nclk();
    chk("R10 no req unselected", req, 1'b0);
    chk("R10 driver released", req_oe, 1'b0);

    // R2: select raises the request one clock later
    @(negedge clk);
    sel = 1; #1;
    chk("R10 driver enabled", req_oe, 1'b1);
    chk("R2 req not yet", req, 1'b0);
    nclk();
    chk("R2 req raised", req, 1'b1);

    // R3: buffer falls before ack, request held
    @(negedge clk); src_rdy = 0;
    repeat (3) nclk();
    chk("R3 held without ack", req, 1'b1);
    // R8: ack seen with buffer not ready -> pause
    @(negedge clk); ack = 1;
    nclk();
    chk("R8 pause drop", req, 1'b0);
    // R9: stays low under ack even with data ready
    @(negedge clk); src_rdy = 1;
    repeat (2) nclk();
    chk("R9 low while ack", req, 1'b0);
    @(negedge clk); ack = 0;
    nclk();
    chk("R9 low one clock after ack release", req, 1'b0);
    nclk();
    chk("R9 re-raise", req, 1'b1);

    // R5: unacknowledged strobes ignored and not counted (block of 1)
    blk = 3'd1;
    word(1'b1, 1'b0, 1'b1);
    word(1'b0, 1'b0, 1'b1);
    @(negedge clk); ack = 1;
    word(1'b1, 1'b1, 1'b0);
    @(negedge clk); ack = 0;
    repeat (2) nclk();
    chk("R9 re-raise after block", req, 1'b1);

    // R7: sweep every block size in both directions
    for (int d = 0; d < 2; d++) begin
      for (int b = 0; b < (1 << CNT_W); b++) begin
        automatic int lim = (b == 0) ? (1 << CNT_W) : b;
        @(negedge clk);
        dir_rd = d[0]; src_rdy = d[0]; snk_rdy = ~d[0]; blk = b[CNT_W-1:0];
        repeat (3) nclk();
        chk("R2 req before block", req, 1'b1);
        @(negedge clk); ack = 1;
        for (int w = 0; w < lim; w++)
          word(d[0], 1'b1, (w != lim - 1));
        repeat (2) nclk();
        chk("R9 low after block under ack", req, 1'b0);
        @(negedge clk); ack = 0;
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule